// File: doc/BRIEF.md
# Two-Level Interrupt Status Aggregator

This block gathers event pulses from the transmit, receive and link logic of a network controller into sticky status bits. It folds them into one level-sensitive interrupt line. There are two status levels. A 32-bit global status register collects the data-path events. A 16-bit management status register collects the link events. The management level is reduced to a single summary bit, bit 23, inside the global status.

Software uses a word-wide register port with a single strobe, a direction bit and an address. It reads status, writes the mask registers, and acknowledges events by reading. Reading the global status clears it. Reading the management status clears it. Two extra offsets mirror the global status and global mask registers, so that software which uses those addresses keeps working. A small request register at offset 0 acknowledges transmit-reset and receive-reset requests at once.

Top module: `intagg_top`

## Requirements
- R1: After reset, the global mask reads 0xFF7FFFFF and the management mask reads 0x0000FFFF. The global status, management status and request register read 0. `irqOut` is low.
- R2: A pulse sets a sticky global status bit, which stays set until it is cleared. The bit positions are: `evRxDone` bit 16, `evRxNoDesc` bit 17, `evTxDesc` bit 24, `evTxAll` bit 25.
- R3: A pulse on `evLink` sets all 16 management status bits.
- R4: A read of the global status (0x100) returns its current value and then clears every stored bit. Bit 23 is not stored. It always reads as the live management summary, and writes to it have no effect.
- R5: A read of the management status (0x200) returns its value and then clears all 16 bits.
- R6: Offset 0x108 acts as the global status (0x100), and offset 0x10C acts as the global mask (0x104), for both reads and writes, including the clearing read.
- R7: A mask bit of 1 disables the matching status bit. `irqOut` is high exactly when some global status bit other than bit 23 is set while its global mask bit is 0, or when the management summary is set.
- R8: The management summary (global status bit 23) is 1 whenever some management status bit is set while its management mask bit is 0. Global mask bit 23 has no effect on the summary or on the interrupt.
- R9: A write to the request register (offset 0) stores all bits except bits 0 (transmit reset) and 1 (receive reset). Those two bits read back 0 at once.
- R10: An event pulse in the same cycle as a clearing read or a status write wins, and its bit is set afterwards.
- R11: `irqOut` is registered. It shows the register state that held one clock edge earlier.
- R12: The management status is at 0x200 and the management mask at 0x204. Reads of unmapped offsets return 0, and writes to them change nothing.
- R13: `regRdData` is valid in the same cycle as a read strobe (`regEn`=1, `regWr`=0), and it is 0 when there is no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regEn | input | 1 | Register access strobe |
| regWr | input | 1 | 1 = write, 0 = read |
| regAddr | input | 12 | Byte offset of the access |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, same cycle as the read strobe |
| evRxDone | input | 1 | Receive frame handed to host |
| evRxNoDesc | input | 1 | No receive descriptor available |
| evTxDesc | input | 1 | Transmit descriptor consumed |
| evTxAll | input | 1 | Transmit queue fully drained |
| evLink | input | 1 | Link state changed |
| irqOut | output | 1 | Level interrupt request |

## Verification
The bench targets an event that lands in the same cycle as a clearing read. A design that gives the clear priority would lose that event, and the next read would show the bit missing. It also checks that the summary bit survives a global read and ignores the global mask. If the summary were stored, or masked by the global mask, the interrupt would drop while a management event is still pending. The bench drives the alias offsets and the request register. A wrong alias would leave the real register unchanged, and a request bit that does not self-clear would read back as 1. Every cycle it compares `irqOut` with the state from one edge earlier. This catches an interrupt that is combinational or delayed by too many cycles.

// File: rtl/intagg_pkg.sv
package intagg_pkg;

  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_REQ   = 3'd1,
    SEL_GSTAT = 3'd2,
    SEL_GMASK = 3'd3,
    SEL_MSTAT = 3'd4,
    SEL_MMASK = 3'd5
  } rdSel_e;

  // strobes from the decoder to the register datapath
  typedef struct packed {
    logic   wrReq;
    logic   wrGStat;
    logic   wrGMask;
    logic   wrMStat;
    logic   wrMMask;
    logic   clrGStat;
    logic   clrMStat;
    rdSel_e rdSel;
  } regStrobes_t;

endpackage

// File: rtl/intagg_ctrl.sv
module intagg_ctrl
  import intagg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REQ_OFF    = 'h000,
  parameter logic [ADDR_W-1:0] GSTAT_OFF  = 'h100,
  parameter logic [ADDR_W-1:0] GMASK_OFF  = 'h104,
  parameter logic [ADDR_W-1:0] GSTAT_ALIAS = 'h108,
  parameter logic [ADDR_W-1:0] GMASK_ALIAS = 'h10C,
  parameter logic [ADDR_W-1:0] MSTAT_OFF  = 'h200,
  parameter logic [ADDR_W-1:0] MMASK_OFF  = 'h204
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regEn,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobes_t       strb
);

  logic [ADDR_W-1:0] canonAddr;
  logic hitReq, hitGStat, hitGMask, hitMStat, hitMMask;
  logic doWr, doRd;

  // fold the alias offsets onto their primary registers
  always_comb begin
    canonAddr = regAddr;
    if (regAddr == GSTAT_ALIAS) canonAddr = GSTAT_OFF;
    if (regAddr == GMASK_ALIAS) canonAddr = GMASK_OFF;
  end

  assign hitReq   = (canonAddr == REQ_OFF);
  assign hitGStat = (canonAddr == GSTAT_OFF);
  assign hitGMask = (canonAddr == GMASK_OFF);
  assign hitMStat = (canonAddr == MSTAT_OFF);
  assign hitMMask = (canonAddr == MMASK_OFF);

  assign doWr = regEn & regWr;
  assign doRd = regEn & ~regWr;

  always_comb begin
    strb          = '0;
    strb.rdSel    = SEL_NONE;
    strb.wrReq    = doWr & hitReq;
    strb.wrGStat  = doWr & hitGStat;
    strb.wrGMask  = doWr & hitGMask;
    strb.wrMStat  = doWr & hitMStat;
    strb.wrMMask  = doWr & hitMMask;
    strb.clrGStat = doRd & hitGStat;
    strb.clrMStat = doRd & hitMStat;
    if (doRd) begin
      if (hitReq)   strb.rdSel = SEL_REQ;
      if (hitGStat) strb.rdSel = SEL_GSTAT;
      if (hitGMask) strb.rdSel = SEL_GMASK;
      if (hitMStat) strb.rdSel = SEL_MSTAT;
      if (hitMMask) strb.rdSel = SEL_MMASK;
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrReq, strb.wrGStat, strb.wrGMask, strb.wrMStat, strb.wrMMask,
              strb.clrGStat, strb.clrMStat})); // R6

  AST_ALIAS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (regEn && !regWr && regAddr == GSTAT_ALIAS) |-> strb.clrGStat); // R6

endmodule

// File: rtl/intagg_dp.sv
module intagg_dp
  import intagg_pkg::*;
#(
  parameter int GLB_W         = 32,
  parameter int MGT_W         = 16,
  parameter int SUM_BIT       = 23,
  parameter int RX_DONE_BIT   = 16,
  parameter int RX_NODESC_BIT = 17,
  parameter int TX_DESC_BIT   = 24,
  parameter int TX_ALL_BIT    = 25,
  parameter int REQ_W         = 2,
  parameter logic [GLB_W-1:0] GMASK_RST = 32'hFF7F_FFFF,
  parameter logic [MGT_W-1:0] MMASK_RST = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobes_t      strb,
  input  logic [GLB_W-1:0] wrData,
  input  logic             evRxDone,
  input  logic             evRxNoDesc,
  input  logic             evTxDesc,
  input  logic             evTxAll,
  input  logic             evLink,
  output logic [GLB_W-1:0] rdData,
  output logic             irqOut
);

  localparam logic [GLB_W-1:0] SUM_MASK = GLB_W'(1) << SUM_BIT;
  localparam logic [GLB_W-1:0] REQ_MASK = (GLB_W'(1) << REQ_W) - GLB_W'(1);

  logic [GLB_W-1:0] reqReg, gStat, gMask;
  logic [MGT_W-1:0] mStat, mMask;
  logic             irqQ;

  logic [GLB_W-1:0] evSet, sumVec, gView, gStatNext;
  logic [MGT_W-1:0] mStatNext;
  logic             mgmtPend, irqNext;

  always_comb begin
    evSet = '0;
    evSet[RX_DONE_BIT]   = evRxDone;
    evSet[RX_NODESC_BIT] = evRxNoDesc;
    evSet[TX_DESC_BIT]   = evTxDesc;
    evSet[TX_ALL_BIT]    = evTxAll;
  end

  // second level: management status reduced to one summary bit
  assign mgmtPend = |(mStat & ~mMask);

  always_comb begin
    sumVec = '0;
    sumVec[SUM_BIT] = mgmtPend;
  end

  assign gView = gStat | sumVec;

  // writes and clearing reads first, events OR-ed last so they win
  always_comb begin
    gStatNext = gStat;
    if (strb.wrGStat)       gStatNext = wrData & ~SUM_MASK;
    else if (strb.clrGStat) gStatNext = '0;
    gStatNext = gStatNext | evSet;
  end

  always_comb begin
    mStatNext = mStat;
    if (strb.wrMStat)       mStatNext = wrData[MGT_W-1:0];
    else if (strb.clrMStat) mStatNext = '0;
    if (evLink)             mStatNext = '1;
  end

  assign irqNext = (|(gStat & ~gMask & ~SUM_MASK)) | mgmtPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqReg <= '0;
      gStat  <= '0;
      gMask  <= GMASK_RST;
      mStat  <= '0;
      mMask  <= MMASK_RST;
      irqQ   <= 1'b0;
    end else begin
      if (strb.wrReq)   reqReg <= wrData & ~REQ_MASK;
      if (strb.wrGMask) gMask  <= wrData;
      if (strb.wrMMask) mMask  <= wrData[MGT_W-1:0];
      gStat <= gStatNext;
      mStat <= mStatNext;
      irqQ  <= irqNext;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_REQ:   rdData = reqReg;
      SEL_GSTAT: rdData = gView;
      SEL_GMASK: rdData = gMask;
      SEL_MSTAT: rdData = {{(GLB_W-MGT_W){1'b0}}, mStat};
      SEL_MMASK: rdData = {{(GLB_W-MGT_W){1'b0}}, mMask};
      default:   rdData = '0;
    endcase
  end

  assign irqOut = irqQ;

  AST_RXDONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    evRxDone |=> gStat[RX_DONE_BIT]); // R2

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (gStat[TX_DESC_BIT] && !strb.wrGStat && !strb.clrGStat) |=> gStat[TX_DESC_BIT]); // R2

  AST_LINK_FILL: assert property (@(posedge clk) disable iff (!rstN)
    evLink |=> (&mStat)); // R3

  AST_GSTAT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrGStat && !evRxDone && !evRxNoDesc && !evTxDesc && !evTxAll) |=> (gStat == '0)); // R4

  AST_MSTAT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrMStat && !evLink) |=> (mStat == '0)); // R5

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrGStat && evTxAll) |=> gStat[TX_ALL_BIT]); // R10

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (gStat == '0 && mStat == '0) |=> !irqOut); // R7

  AST_SUMMARY_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    mgmtPend |=> irqOut); // R8

endmodule

// File: rtl/intagg_top.sv
module intagg_top
  import intagg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int GLB_W  = 32,
  parameter int MGT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regEn,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [GLB_W-1:0]  regWrData,
  output logic [GLB_W-1:0]  regRdData,
  input  logic              evRxDone,
  input  logic              evRxNoDesc,
  input  logic              evTxDesc,
  input  logic              evTxAll,
  input  logic              evLink,
  output logic              irqOut
);

  regStrobes_t strb;

  intagg_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .regEn   (regEn),
    .regWr   (regWr),
    .regAddr (regAddr),
    .strb    (strb)
  );

  intagg_dp #(.GLB_W(GLB_W), .MGT_W(MGT_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (regWrData),
    .evRxDone   (evRxDone),
    .evRxNoDesc (evRxNoDesc),
    .evTxDesc   (evTxDesc),
    .evTxAll    (evTxAll),
    .evLink     (evLink),
    .rdData     (regRdData),
    .irqOut     (irqOut)
  );

endmodule

// File: tb/tb_intagg_top.sv
`timescale 1ns/1ps
module tb_intagg_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regEn = 1'b0, regWr = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        evRxDone = 0, evRxNoDesc = 0, evTxDesc = 0, evTxAll = 0, evLink = 0;
  logic        irqOut;

  always #2.5 clk = ~clk;

  intagg_top dut (
    .clk(clk), .rstN(rstN), .regEn(regEn), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .evRxDone(evRxDone), .evRxNoDesc(evRxNoDesc), .evTxDesc(evTxDesc),
    .evTxAll(evTxAll), .evLink(evLink), .irqOut(irqOut)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state
  logic [31:0] mReq, mGS, mGM;
  logic [15:0] mMS, mMM;
  logic        fPrev;

  function automatic logic mPend();
    return |(mMS & ~mMM);
  endfunction

  function automatic logic mIrq();
    return (|(mGS & ~mGM & ~32'h0080_0000)) | mPend();
  endfunction

  function automatic logic [11:0] canon(input logic [11:0] a);
    if (a == 12'h108) return 12'h100;
    if (a == 12'h10C) return 12'h104;
    return a;
  endfunction

  function automatic logic [31:0] mRead(input logic [11:0] a);
    case (canon(a))
      12'h000: return mReq;
      12'h100: return mGS | (32'(mPend()) << 23);
      12'h104: return mGM;
      12'h200: return {16'h0, mMS};
      12'h204: return {16'h0, mMM};
      default: return 32'h0;
    endcase
  endfunction

  task automatic mApply(input bit doOp, input bit isWr, input logic [11:0] a,
                        input logic [31:0] d, input logic [4:0] ev);
    if (doOp && isWr) begin
      case (canon(a))
        12'h000: mReq = d & ~32'h3;
        12'h100: mGS  = d & ~32'h0080_0000;
        12'h104: mGM  = d;
        12'h200: mMS  = d[15:0];
        12'h204: mMM  = d[15:0];
        default: ;
      endcase
    end else if (doOp) begin
      if (canon(a) == 12'h100) mGS = '0;
      if (canon(a) == 12'h200) mMS = '0;
    end
    if (ev[0]) mGS[16] = 1'b1;
    if (ev[1]) mGS[17] = 1'b1;
    if (ev[2]) mGS[24] = 1'b1;
    if (ev[3]) mGS[25] = 1'b1;
    if (ev[4]) mMS = 16'hFFFF;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: check irq, drive stimulus, check read data, update model
  task automatic step(input bit doOp, input bit isWr, input logic [11:0] a,
                      input logic [31:0] d, input logic [4:0] ev, input string tag);
    @(negedge clk);
    chk({"R11 irq ", tag}, {31'h0, irqOut}, {31'h0, fPrev});
    fPrev = mIrq();
    regEn = doOp; regWr = isWr; regAddr = a; regWrData = d;
    {evLink, evTxAll, evTxDesc, evRxNoDesc, evRxDone} = ev;
    #1;
    if (doOp && !isWr) chk({"rd ", tag}, regRdData, mRead(a));
    else if (!doOp) chk({"R13 idle ", tag}, regRdData, 32'h0);
    mApply(doOp, isWr, a, d, ev);
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    step(1, 0, a, 32'h0, 5'h0, tag);
  endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    step(1, 1, a, d, 5'h0, tag);
  endtask
  task automatic idle(input logic [4:0] ev, input string tag);
    step(0, 0, 12'h0, 32'h0, ev, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] addrs [8];
    void'($urandom(32'd7331));
    addrs = '{12'h000, 12'h100, 12'h104, 12'h108, 12'h10C, 12'h200, 12'h204, 12'h030};
    mReq = '0; mGS = '0; mGM = 32'hFF7F_FFFF; mMS = '0; mMM = 16'hFFFF; fPrev = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    rd(12'h104, "R1 gmask");
    rd(12'h204, "R1 mmask");
    rd(12'h100, "R1 gstat");
    rd(12'h200, "R1 mstat");
    rd(12'h000, "R1 req");
    // R12 unmapped
    wr(12'h030, 32'hDEAD_BEEF, "R12 unmapped wr");
    rd(12'h030, "R12 unmapped rd");
    // R2 events, masked by default
    idle(5'b01111, "R2 events");
    rd(12'h108, "R2 R6 alias read");
    idle(5'b01111, "R2 again");
    wr(12'h104, 32'hFDFF_FFFF, "R7 unmask bit25");
    idle(5'h0, "R7 settle");
    idle(5'h0, "R7 irq high");
    rd(12'h100, "R4 clear");
    rd(12'h100, "R4 after clear");
    idle(5'h0, "R7 irq low");
    // R3 / R8 summary
    idle(5'b10000, "R3 link");
    rd(12'h200, "R3 R12 mstat");
    idle(5'b10000, "R3 link again");
    wr(12'h204, 32'h0000_0001, "R8 unmask mgmt");
    rd(12'h100, "R8 summary read");
    wr(12'h10C, 32'hFFFF_FFFF, "R6 R8 gmask alias all");
    rd(12'h104, "R6 gmask");
    idle(5'h0, "R8 irq stays");
    rd(12'h100, "R4 summary survives");
    wr(12'h100, 32'h0080_0000, "R4 write bit23");
    rd(12'h200, "R5 clear");
    rd(12'h200, "R5 after clear");
    rd(12'h100, "R8 summary gone");
    // R9 request register
    wr(12'h000, 32'h0000_00A7, "R9 wr");
    rd(12'h000, "R9 rd");
    // R10 event wins over clear and write
    wr(12'h104, 32'h0, "R10 unmask");
    step(1, 0, 12'h100, 32'h0, 5'b01000, "R10 read+event");
    rd(12'h100, "R10 kept");
    step(1, 1, 12'h108, 32'h0, 5'b00001, "R10 write+event");
    rd(12'h100, "R10 kept wr");
    step(1, 0, 12'h200, 32'h0, 5'b10000, "R10 mread+link");
    rd(12'h200, "R10 link kept");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [4:0] ev;
      int r;
      r  = $urandom_range(0, 99);
      ev = ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'h0;
      if (ev[4] && $urandom_range(0, 2) != 0) ev[4] = 1'b0;
      if (r < 45)
        step(1, 0, addrs[$urandom_range(0, 7)], 32'h0, ev, "R7 rand rd");
      else if (r < 75)
        step(1, 1, addrs[$urandom_range(0, 7)], $urandom, ev, "R6 rand wr");
      else
        step(0, 0, 12'h0, 32'h0, ev, "R2 rand idle");
    end
    idle(5'h0, "R11 tail");
    idle(5'h0, "R11 tail");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule